// File: doc/BRIEF.md
# Display-Side Link Responder

This block sits at the display end of a one-wire-pair parallel bus extender. It takes in a framed serial bit stream, works out what kind of transaction each frame carries, and replays that transaction on a parallel display bus. Write frames put data and control on the bus and then pulse one of two active-low write strobes. Which strobe pulses depends on a select bit in the frame, so that two displays can share one link.

Read frames run in two phases. First the block sets the control lines and releases the data bus (this is modelled by dropping an output-enable). It then pulls the chosen strobe low for a programmable number of cycles so the display can present its data. On the rising edge of the strobe it samples the bus. It then sends the sampled word back on the transmit side of the line, followed by an all-zero control field, and hands the line back to the receiver.

SPI frames carry only the control field. They refresh the control outputs and copy the SPI clock and data bits onto two data-bus lines. A standby input freezes all state. Frames with an unused type code are dropped and leave a sticky error flag.

Top module: `slv_link_responder`

## Requirements
- R1: A frame is 27 bits sent MSB first, one bit per cycle with `rx_valid`, and its first bit is marked by `rx_sof`. Bit 26:25 is the type (01 write, 10 read, 11 SPI, 00 unused), bit 24 is the strobe select, bits 23:18 are control and bits 17:0 are data. Bits that arrive without a preceding `rx_sof` are ignored. A new `rx_sof` restarts the frame.
- R2: On a write frame, `data_o`, `ctrl_o` and `data_oe=1` take effect in the cycle after the last bit. In that same cycle the selected strobe (`wstb0_n` for select 0, `wstb1_n` for select 1) goes low and stays low for exactly `STB_LOW` cycles. The other strobe stays high.
- R3: On a read frame, `ctrl_o` is updated and `data_o` is left unchanged. `data_oe` drops to 0 and `line_dir` becomes 1. The selected strobe goes low for `STB_LOW` cycles, starting in the cycle after the last bit.
- R4: `data_i` is sampled at the clock edge where the strobe rises. Starting in the next cycle, `tx_valid` is high for 24 cycles. Over those cycles `tx_bit` carries the 18 sampled bits MSB first, followed by 6 zero bits.
- R5: In the cycle after the last response bit, `tx_valid` and `line_dir` are 0 and the next frame is accepted.
- R6: On an SPI frame, `ctrl_o` takes the received control field. `data_o[7]` takes control bit 5 and `data_o[6]` takes control bit 4. All other data bits are held, `data_oe=1`, and no strobe pulses.
- R7: A frame with type 00 changes no output other than `err_o`. `err_o` rises and stays high until reset.
- R8: While `stby` is high, every output holds its value and incoming bits are ignored. A strobe pulse already in progress resumes its count when `stby` falls.
- R9: After reset, `data_o=0`, `ctrl_o=0`, `data_oe=0`, both strobes are high, and `line_dir`, `tx_valid` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby | input | 1 | Standby: freeze all state |
| rx_valid | input | 1 | Received bit valid |
| rx_sof | input | 1 | Marks first bit of a frame |
| rx_bit | input | 1 | Received serial bit |
| tx_valid | output | 1 | Response bit valid |
| tx_bit | output | 1 | Response serial bit |
| line_dir | output | 1 | 1 while the block owns the line for a read |
| data_i | input | 18 | Data returned by the display |
| data_o | output | 18 | Data driven to the display |
| data_oe | output | 1 | Data bus output enable |
| ctrl_o | output | 6 | Control lines to the display |
| wstb0_n | output | 1 | Write/read strobe, display 0, active low |
| wstb1_n | output | 1 | Write/read strobe, display 1, active low |
| err_o | output | 1 | Sticky unknown-frame flag |

## Verification
The bench builds the block with `STB_LOW=3` rather than the default 4. With a short window, both the first and the last low cycle of each strobe can be checked, and the rising edge at which the display data is sampled falls inside a small fixed offset that the bench can count exactly. The random mix interleaves all four frame types, so a read is often followed by a write or SPI frame right after the line is handed back. Directed cases cover a standby freeze in the middle of a strobe, restarted frames and bits without a start marker.

// File: rtl/slv_link_pkg.sv
package slv_link_pkg;
    localparam int CTRL_W      = 6;
    localparam int DATA_W      = 18;
    localparam int SPI_CLK_BIT = 7;
    localparam int SPI_DAT_BIT = 6;

    typedef enum logic [1:0] {
        FT_BAD   = 2'b00,
        FT_WRITE = 2'b01,
        FT_READ  = 2'b10,
        FT_SPI   = 2'b11
    } frame_type_e;

    typedef struct packed {
        frame_type_e         ftype;
        logic                sel;
        logic [CTRL_W-1:0]   ctrl;
        logic [DATA_W-1:0]   data;
    } frame_t;

    localparam int FRAME_W = $bits(frame_t);
    localparam int RSP_W   = DATA_W + CTRL_W;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_TX   = 2'd2
    } state_e;

    // SPI clock and data sit in the two top control bits
    function automatic logic [DATA_W-1:0] spi_mirror(
        input logic [DATA_W-1:0] cur,
        input logic [CTRL_W-1:0] c
    );
        logic [DATA_W-1:0] r;
        r = cur;
        r[SPI_CLK_BIT] = c[CTRL_W-1];
        r[SPI_DAT_BIT] = c[CTRL_W-2];
        return r;
    endfunction
endpackage

// File: rtl/slv_deframer.sv
module slv_deframer
    import slv_link_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   rx_valid,
    input  logic   rx_sof,
    input  logic   rx_bit,
    output frame_t frm,
    output logic   done
);
    localparam int CW = $clog2(W + 1);

    logic [W-2:0]  sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
        end else if (en && rx_valid) begin
            if (rx_sof) begin
                sh  <= {sh[W-3:0], rx_bit};
                cnt <= CW'(1);
            end else if (cnt != '0) begin
                sh  <= {sh[W-3:0], rx_bit};
                cnt <= (cnt == CW'(W - 1)) ? '0 : cnt + CW'(1);
            end
        end
    end

    assign done = en && rx_valid && !rx_sof && (cnt == CW'(W - 1));
    assign frm  = frame_t'({sh, rx_bit});
endmodule

// File: rtl/slv_strobe_gen.sv
module slv_strobe_gen #(
    parameter int LOW_CYC = 4,
    parameter int N_STB   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             fire,
    input  logic             sel,
    output logic [N_STB-1:0] stb_n,
    output logic             rise
);
    localparam int CW = $clog2(LOW_CYC + 1);

    logic          active;
    logic          sel_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sel_q  <= 1'b0;
            cnt    <= '0;
        end else if (en) begin
            if (fire) begin
                active <= 1'b1;
                sel_q  <= sel;
                cnt    <= CW'(LOW_CYC - 1);
            end else if (active) begin
                if (cnt == '0) active <= 1'b0;
                else           cnt    <= cnt - CW'(1);
            end
        end
    end

    assign rise = en && active && (cnt == '0);

    for (genvar i = 0; i < N_STB; i++) begin : g_stb
        assign stb_n[i] = !(active && (sel_q == 1'(i)));
    end
endmodule

// File: rtl/slv_tx_serializer.sv
module slv_tx_serializer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         tx_bit,
    output logic         last
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
        end else if (en) begin
            if (load) begin
                sh  <= load_val;
                cnt <= CW'(W);
            end else if (cnt != '0) begin
                sh  <= {sh[W-2:0], 1'b0};
                cnt <= cnt - CW'(1);
            end
        end
    end

    assign busy   = (cnt != '0);
    assign last   = en && (cnt == CW'(1));
    assign tx_bit = sh[W-1];
endmodule

// File: rtl/slv_link_responder.sv
module slv_link_responder
    import slv_link_pkg::*;
#(
    parameter int STB_LOW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stby,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_bit,
    output logic              tx_valid,
    output logic              tx_bit,
    output logic              line_dir,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              wstb0_n,
    output logic              wstb1_n,
    output logic              err_o
);
    state_e            state;
    logic              rd_q;
    logic [DATA_W-1:0] data_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              oe_q;
    logic              err_q;

    frame_t     frm;
    logic       fdone;
    logic       fire;
    logic       stb_rise;
    logic [1:0] stb_n;
    logic       tx_load;
    logic       tx_last;
    logic       run;

    assign run = !stby;

    slv_deframer #(.W(FRAME_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .en       (run && state == S_IDLE),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_bit   (rx_bit),
        .frm      (frm),
        .done     (fdone)
    );

    assign fire = fdone && (frm.ftype == FT_WRITE || frm.ftype == FT_READ);

    slv_strobe_gen #(.LOW_CYC(STB_LOW), .N_STB(2)) u_stb (
        .clk   (clk),
        .rst   (rst),
        .en    (run),
        .fire  (fire),
        .sel   (frm.sel),
        .stb_n (stb_n),
        .rise  (stb_rise)
    );

    assign tx_load = stb_rise && rd_q && (state == S_LOW);

    slv_tx_serializer #(.W(RSP_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .en       (run),
        .load     (tx_load),
        .load_val ({data_i, {CTRL_W{1'b0}}}),
        .busy     (tx_valid),
        .tx_bit   (tx_bit),
        .last     (tx_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            rd_q   <= 1'b0;
            data_q <= '0;
            ctrl_q <= '0;
            oe_q   <= 1'b0;
            err_q  <= 1'b0;
        end else if (run) begin
            unique case (state)
                S_IDLE: if (fdone) begin
                    unique case (frm.ftype)
                        FT_WRITE: begin
                            data_q <= frm.data;
                            ctrl_q <= frm.ctrl;
                            oe_q   <= 1'b1;
                            rd_q   <= 1'b0;
                            state  <= S_LOW;
                        end
                        FT_READ: begin
                            ctrl_q <= frm.ctrl;
                            oe_q   <= 1'b0;
                            rd_q   <= 1'b1;
                            state  <= S_LOW;
                        end
                        FT_SPI: begin
                            ctrl_q <= frm.ctrl;
                            data_q <= spi_mirror(data_q, frm.ctrl);
                            oe_q   <= 1'b1;
                        end
                        default: err_q <= 1'b1;
                    endcase
                end
                S_LOW: if (stb_rise) state <= rd_q ? S_TX : S_IDLE;
                S_TX:  if (tx_last)  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign line_dir = (state == S_LOW && rd_q) || (state == S_TX);
    assign data_o   = data_q;
    assign ctrl_o   = ctrl_q;
    assign data_oe  = oe_q;
    assign err_o    = err_q;
    assign wstb0_n  = stb_n[0];
    assign wstb1_n  = stb_n[1];
endmodule

// File: rtl/slv_link_responder_chk.sv
module slv_link_responder_chk #(
    parameter int STB_LOW = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        stby,
    input logic        tx_valid,
    input logic        line_dir,
    input logic        data_oe,
    input logic [17:0] data_o,
    input logic [5:0]  ctrl_o,
    input logic        wstb0_n,
    input logic        wstb1_n,
    input logic        err_o
);
    localparam int CW = $clog2(STB_LOW + 2);
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || (wstb0_n && wstb1_n)) low_cnt <= '0;
        else if (!stby)                  low_cnt <= low_cnt + CW'(1);
    end

    // R2: never both strobes low at once
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (wstb0_n || wstb1_n));

    // R2: a strobe low period never exceeds the programmed length
    p_low_len_r2: assert property (@(posedge clk) disable iff (rst)
        (!wstb0_n || !wstb1_n) |-> (low_cnt < CW'(STB_LOW)));

    // R2: a strobe rises only after the full programmed length
    p_rise_len_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(wstb0_n && wstb1_n) |-> ($past(low_cnt) == CW'(STB_LOW - 1)));

    // R3: response is never sent while the data bus is driven
    p_oe_off_r3: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !data_oe);

    // R4: response only while the block owns the line
    p_dir_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> line_dir);

    // R7: error flag is sticky
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R8: standby freezes the parallel side
    p_stby_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(stby) && !$past(rst)) |->
        ($stable(data_o) && $stable(ctrl_o) && $stable(wstb0_n) &&
         $stable(wstb1_n) && $stable(data_oe) && $stable(line_dir)));
endmodule

bind slv_link_responder slv_link_responder_chk #(.STB_LOW(STB_LOW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stby     (stby),
    .tx_valid (tx_valid),
    .line_dir (line_dir),
    .data_oe  (data_oe),
    .data_o   (data_o),
    .ctrl_o   (ctrl_o),
    .wstb0_n  (wstb0_n),
    .wstb1_n  (wstb1_n),
    .err_o    (err_o)
);

// File: tb/tb_slv_link_responder.sv
module tb_slv_link_responder;
    localparam int L = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stby = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_bit = 1'b0;
    logic        tx_valid, tx_bit, line_dir, data_oe, wstb0_n, wstb1_n, err_o;
    logic [17:0] data_i = '0;
    logic [17:0] data_o;
    logic [5:0]  ctrl_o;

    int checks = 0;
    int fails  = 0;

    logic [17:0] e_data = '0;
    logic [5:0]  e_ctrl = '0;
    logic        e_oe   = 1'b0;
    logic        e_err  = 1'b0;

    always #4 clk = ~clk;

    slv_link_responder #(.STB_LOW(L)) dut (
        .clk(clk), .rst(rst), .stby(stby),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_bit(rx_bit),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .line_dir(line_dir),
        .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
        .ctrl_o(ctrl_o), .wstb0_n(wstb0_n), .wstb1_n(wstb1_n), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [26:0] mk(input logic [1:0] ft, input logic sel,
                                       input logic [5:0] c, input logic [17:0] d);
        return {ft, sel, c, d};
    endfunction

    function automatic logic [17:0] mirror(input logic [17:0] d, input logic [5:0] c);
        logic [17:0] r = d;
        r[7] = c[5];
        r[6] = c[4];
        return r;
    endfunction

    // drives nbits bits MSB first; returns at the negedge after the last bit's edge
    task automatic send(input logic [26:0] f, input bit sof, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = sof && (i == 0);
            rx_bit   = f[26-i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
    endtask

    task automatic chk_static(input string tag);
        chk({tag, " data_o"}, 32'(data_o), 32'(e_data));
        chk({tag, " ctrl_o"}, 32'(ctrl_o), 32'(e_ctrl));
        chk({tag, " data_oe"}, 32'(data_oe), 32'(e_oe));
        chk({tag, " err_o"}, 32'(err_o), 32'(e_err));
    endtask

    task automatic chk_strobe(input string tag, input bit lo, input logic sel);
        chk({tag, " wstb0_n"}, 32'(wstb0_n), 32'(!(lo && sel == 1'b0)));
        chk({tag, " wstb1_n"}, 32'(wstb1_n), 32'(!(lo && sel == 1'b1)));
    endtask

    task automatic do_write(input logic sel, input logic [5:0] c, input logic [17:0] d,
                            input int stall);
        send(mk(2'b01, sel, c, d), 1'b1, 27);
        e_data = d; e_ctrl = c; e_oe = 1'b1;
        chk_static("R2 write outputs");
        chk_strobe("R2 strobe fall", 1'b1, sel);
        if (stall > 0) begin
            stby = 1'b1;
            repeat (stall) @(negedge clk);
            chk_strobe("R8 strobe frozen", 1'b1, sel);
            chk_static("R8 outputs frozen");
            stby = 1'b0;
        end
        for (int k = 1; k < L; k++) begin
            @(negedge clk);
            chk_strobe("R2 strobe held low", 1'b1, sel);
        end
        @(negedge clk);
        chk_strobe("R2 strobe risen", 1'b0, sel);
    endtask

    task automatic do_read(input logic sel, input logic [5:0] c, input logic [17:0] rd);
        logic [23:0] rsp;
        send(mk(2'b10, sel, c, 18'h3ffff), 1'b1, 27);
        e_ctrl = c; e_oe = 1'b0;
        chk_static("R3 read outputs");
        chk("R3 line_dir", 32'(line_dir), 32'd1);
        chk_strobe("R3 strobe fall", 1'b1, sel);
        data_i = rd;
        for (int k = 1; k < L; k++) begin
            @(negedge clk);
            chk_strobe("R3 strobe held low", 1'b1, sel);
        end
        @(negedge clk);
        data_i = ~rd;
        chk_strobe("R4 strobe risen", 1'b0, sel);
        rsp = {rd, 6'b0};
        for (int b = 0; b < 24; b++) begin
            chk("R4 tx_valid", 32'(tx_valid), 32'd1);
            chk("R4 tx_bit", 32'(tx_bit), 32'(rsp[23-b]));
            @(negedge clk);
        end
        chk("R5 tx_valid low", 32'(tx_valid), 32'd0);
        chk("R5 line_dir low", 32'(line_dir), 32'd0);
        chk_static("R3 after read");
    endtask

    task automatic do_spi(input logic [5:0] c, input logic [17:0] junk);
        send(mk(2'b11, 1'b0, c, junk), 1'b1, 27);
        e_ctrl = c; e_data = mirror(e_data, c); e_oe = 1'b1;
        chk_static("R6 spi outputs");
        chk_strobe("R6 no strobe", 1'b0, 1'b0);
        @(negedge clk);
        chk_strobe("R6 no strobe later", 1'b0, 1'b0);
    endtask

    task automatic do_bad(input logic sel, input logic [5:0] c, input logic [17:0] d);
        send(mk(2'b00, sel, c, d), 1'b1, 27);
        e_err = 1'b1;
        chk_static("R7 unknown dropped");
        chk_strobe("R7 no strobe", 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk_static("R9 reset");
        chk_strobe("R9 reset strobes", 1'b0, 1'b0);
        chk("R9 line_dir", 32'(line_dir), 32'd0);
        chk("R9 tx_valid", 32'(tx_valid), 32'd0);

        do_write(1'b0, 6'h2a, 18'h15a5a, 0);
        do_write(1'b1, 6'h15, 18'h2a5a5, 0);
        // R1 bits without start marker ignored
        send(mk(2'b01, 1'b0, 6'h3f, 18'h3ffff), 1'b0, 27);
        chk_static("R1 no sof ignored");
        chk_strobe("R1 no sof strobes", 1'b0, 1'b0);
        // R1 partial frame restarted by new start marker
        send(mk(2'b01, 1'b1, 6'h01, 18'h00001), 1'b1, 10);
        do_write(1'b0, 6'h0c, 18'h0f0f0, 0);
        do_read(1'b1, 6'h33, 18'h2d2d2);
        do_read(1'b0, 6'h00, 18'h3ffff);
        do_spi(6'b100000, 18'h3ffff);
        do_spi(6'b010000, 18'h00000);
        // R8 standby: frame ignored
        stby = 1'b1;
        send(mk(2'b01, 1'b1, 6'h3f, 18'h12345), 1'b1, 27);
        chk_static("R8 standby ignores frame");
        chk_strobe("R8 standby strobes", 1'b0, 1'b0);
        stby = 1'b0;
        // R8 standby mid-strobe
        do_write(1'b1, 6'h21, 18'h31337, 5);
        do_bad(1'b1, 6'h3f, 18'h3ffff);
        do_write(1'b0, 6'h07, 18'h00abc, 0);
        chk("R7 err stays", 32'(err_o), 32'd1);

        for (int n = 0; n < 60; n++) begin
            logic [1:0]  t = 2'($urandom_range(0, 3));
            logic        s = 1'($urandom);
            logic [5:0]  c = 6'($urandom);
            logic [17:0] d = 18'($urandom);
            case (t)
                2'b01:   do_write(s, c, d, 0);
                2'b10:   do_read(s, c, d);
                2'b11:   do_spi(c, d);
                default: do_bad(s, c, d);
            endcase
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        e_data = '0; e_ctrl = '0; e_oe = 1'b0; e_err = 1'b0;
        @(negedge clk);
        chk_static("R9 reset clears err");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule